// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Invalidation Sequencer

The block is a small fully associative translation cache. Every entry maps a linear page number to a physical frame number. Each entry carries a context tag. The tag is either a virtual-processor identifier (VPID), a nested page-table root tag, or both at once (a dual-tagged entry). An entry may also carry a global flag. Lookups present a VPID, a root tag and a page number. The response comes back one cycle later. Fills come from an external page walker and are placed in round-robin order.

A single command port carries invalidation requests. Each request has an operation code, a VPID, a root tag and a page number. An accepted request starts a sweep. The sweep visits the entries a fixed number of lanes per cycle and clears the valid bit of every entry that the operation selects. A completion pulse follows the sweep. While a sweep runs, lookups, fills and new commands are held off through the shared ready output. An undefined operation code produces an error pulse and no sweep.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: After reset no entry is valid, `lk_ready_o` is 1, and `done_o`, `err_o` and `lk_resp_valid_o` are 0. Every lookup misses.
- R2: A lookup is accepted when `lk_valid_i` and `lk_ready_o` are both 1. The next cycle it gives `lk_resp_valid_o`=1 with hit and frame (frame 0 on a miss). A valid entry matches when its page is equal and its kind matches. Kind 1 (VPID-tagged) compares the VPID only. Kind 2 (root-tagged) compares the root tag only. Kind 3 (dual-tagged) compares both. The lowest matching slot wins.
- R3: A fill is taken when `fill_valid_i` and `lk_ready_o` are both 1. It writes the slot at a round-robin pointer that starts at 0 and wraps after the last slot, so the 17th fill replaces the first. A fill offered while a sweep runs is ignored and does not move the pointer.
- R4: Op 0 clears the kind-1 and kind-3 entries that have the command's VPID and page, whatever their root tag.
- R5: Op 1 clears every kind-1 and kind-3 entry with the command's VPID, across all root tags.
- R6: Op 2 clears every kind-1 and kind-3 entry and keeps the kind-2 entries.
- R7: Op 3 clears like op 1 but keeps entries whose global flag is set.
- R8: Op 4 clears every kind-2 and kind-3 entry with the command's root tag, across all VPIDs.
- R9: Op 5 (context switch while VPID tagging is off) clears every kind-1 and kind-3 entry whose VPID is 0.
- R10: Op 6 (nested fault) clears only kind-3 entries that match the command's VPID, root tag and page.
- R11: Op 7 is undefined. It raises `err_o` for one cycle, right after acceptance. It changes no entry and starts no sweep.
- R12: An accepted op 0 to 6 holds `lk_ready_o` low for ENTRIES/LANES cycles (4 by default). `done_o` pulses for one cycle right after the cycle that handles the last group, and `lk_ready_o` is 1 again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpid_i | input | 16 | Lookup VPID |
| lk_root_i | input | 12 | Lookup root tag |
| lk_page_i | input | 20 | Lookup linear page number |
| lk_ready_o | output | 1 | Block idle: lookups and fills accepted |
| lk_resp_valid_o | output | 1 | Lookup response valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_frame_o | output | 20 | Frame number on hit, else 0 |
| fill_valid_i | input | 1 | Fill request |
| fill_kind_i | input | 2 | Entry kind: 1 VPID, 2 root, 3 dual |
| fill_vpid_i | input | 16 | Fill VPID |
| fill_root_i | input | 12 | Fill root tag |
| fill_page_i | input | 20 | Fill page number |
| fill_frame_i | input | 20 | Fill frame number |
| fill_global_i | input | 1 | Fill global flag |
| cmd_valid_i | input | 1 | Invalidation command |
| cmd_op_i | input | 3 | Operation code 0..7 |
| cmd_vpid_i | input | 16 | Command VPID |
| cmd_root_i | input | 12 | Command root tag |
| cmd_page_i | input | 20 | Command page number |
| cmd_ready_o | output | 1 | Command accepted when 1 |
| done_o | output | 1 | Sweep completion pulse |
| err_o | output | 1 | Undefined operation pulse |

## Verification
The assertions check several properties on every cycle. Done comes only in the cycle after the final sweep group. A sweep never runs longer than its group count. An error pulse never overlaps a sweep. Every response follows an accepted request. A cleared entry is invalid the next cycle. The fill pointer steps once per accepted fill. The clearing rules of each operation depend on stored tags, so only the bench scenarios can show them: which kinds and globals survive, that other VPIDs and roots stay intact, and that a refill after wrap-around really replaces the oldest entry.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_VPID = 2'd1,
    KIND_ROOT = 2'd2,
    KIND_DUAL = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    OP_VPID_ADDR  = 3'd0,
    OP_VPID_CTX   = 3'd1,
    OP_VPID_ALL   = 3'd2,
    OP_VPID_KEEPG = 3'd3,
    OP_ROOT_CTX   = 3'd4,
    OP_CTX_SWITCH = 3'd5,
    OP_FAULT_ADDR = 3'd6
  } op_e;

  localparam logic [2:0] OP_LAST_DEF = 3'd6;
endpackage

// File: rtl/tlbi_sweeper.sv
module tlbi_sweeper #(
  parameter int N = 16,
  parameter int LANES = 4,
  parameter int VPID_W = 16,
  parameter int ROOT_W = 12,
  parameter int LPN_W = 20,
  localparam int GROUPS = N / LANES,
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [VPID_W-1:0] cmd_vpid_i,
  input  logic [ROOT_W-1:0] cmd_root_i,
  input  logic [LPN_W-1:0]  cmd_page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [2:0]        op_o,
  output logic [VPID_W-1:0] vpid_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [LPN_W-1:0]  page_o
);
  import tlbi_pkg::*;

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(GROUPS - 1);

  logic             busy_q, done_q, err_q;
  logic [GRP_W-1:0] grp_q;
  logic             op_ok;

  assign op_ok = (cmd_op_i <= OP_LAST_DEF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      grp_q  <= '0;
      op_o   <= '0;
      vpid_o <= '0;
      root_o <= '0;
      page_o <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        if (grp_q == LAST_GRP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          grp_q  <= '0;
        end else begin
          grp_q <= grp_q + 1'b1;
        end
      end else if (cmd_valid_i) begin
        if (!op_ok) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          grp_q  <= '0;
          op_o   <= cmd_op_i;
          vpid_o <= cmd_vpid_i;
          root_o <= cmd_root_i;
          page_o <= cmd_page_i;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign grp_o  = grp_q;

  // independent run-length counter for the sweep bound
  logic [GRP_W:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else if (busy_q) run_cnt <= run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_q) && $past(grp_q) == LAST_GRP)); // R12
  AST_SWEEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (run_cnt < (GRP_W+1)'(GROUPS))); // R12
  AST_ERR_NO_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_q && !done_q)); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(cmd_valid_i) && $past(cmd_op_i) > OP_LAST_DEF)); // R11
endmodule

// File: rtl/tlbi_entry_store.sv
module tlbi_entry_store #(
  parameter int N = 16,
  parameter int LANES = 4,
  parameter int VPID_W = 16,
  parameter int ROOT_W = 12,
  parameter int LPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int GROUPS = N / LANES,
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [1:0]        fill_kind_i,
  input  logic [VPID_W-1:0] fill_vpid_i,
  input  logic [ROOT_W-1:0] fill_root_i,
  input  logic [LPN_W-1:0]  fill_page_i,
  input  logic [PFN_W-1:0]  fill_frame_i,
  input  logic              fill_glb_i,
  input  logic              sw_act_i,
  input  logic [GRP_W-1:0]  sw_grp_i,
  input  logic [2:0]        sw_op_i,
  input  logic [VPID_W-1:0] sw_vpid_i,
  input  logic [ROOT_W-1:0] sw_root_i,
  input  logic [LPN_W-1:0]  sw_page_i,
  output logic [N-1:0]      valid_o,
  output logic [1:0]        kind_o  [N],
  output logic [VPID_W-1:0] vpid_o  [N],
  output logic [ROOT_W-1:0] root_o  [N],
  output logic [LPN_W-1:0]  page_o  [N],
  output logic [PFN_W-1:0]  frame_o [N]
);
  import tlbi_pkg::*;

  logic [N-1:0] valid_q, glb_q, clr;

  function automatic logic clr_match(input logic [2:0] op, input logic [1:0] k,
                                     input logic [VPID_W-1:0] ev,
                                     input logic [ROOT_W-1:0] er,
                                     input logic [LPN_W-1:0] ep, input logic eg);
    logic has_v, has_r, m;
    has_v = k[0];
    has_r = k[1];
    case (op)
      OP_VPID_ADDR:  m = has_v && ev == sw_vpid_i && ep == sw_page_i;
      OP_VPID_CTX:   m = has_v && ev == sw_vpid_i;
      OP_VPID_ALL:   m = has_v;
      OP_VPID_KEEPG: m = has_v && ev == sw_vpid_i && !eg;
      OP_ROOT_CTX:   m = has_r && er == sw_root_i;
      OP_CTX_SWITCH: m = has_v && ev == '0;
      OP_FAULT_ADDR: m = has_v && has_r && ev == sw_vpid_i && er == sw_root_i &&
                         ep == sw_page_i;
      default:       m = 1'b0;
    endcase
    return m;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign clr[i] = sw_act_i && (sw_grp_i == GRP_W'(i / LANES)) &&
                    clr_match(sw_op_i, kind_o[i], vpid_o[i], root_o[i], page_o[i], glb_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[i] <= 1'b0;
      else if (fill_en_i && fill_idx_i == IDX_W'(i)) valid_q[i] <= 1'b1;
      else if (clr[i]) valid_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (fill_en_i && fill_idx_i == IDX_W'(i)) begin
        kind_o[i]  <= fill_kind_i;
        vpid_o[i]  <= fill_vpid_i;
        root_o[i]  <= fill_root_i;
        page_o[i]  <= fill_page_i;
        frame_o[i] <= fill_frame_i;
        glb_q[i]   <= fill_glb_i;
      end
    end

    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[i] |=> !valid_q[i]); // R12
  end

  assign valid_o = valid_q;

  AST_FILL_SWEEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && sw_act_i)); // R3
endmodule

// File: rtl/tlbi_lookup.sv
module tlbi_lookup #(
  parameter int N = 16,
  parameter int VPID_W = 16,
  parameter int ROOT_W = 12,
  parameter int LPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VPID_W-1:0] vpid_i,
  input  logic [ROOT_W-1:0] root_i,
  input  logic [LPN_W-1:0]  page_i,
  input  logic [N-1:0]      valid_i,
  input  logic [1:0]        kind_i  [N],
  input  logic [VPID_W-1:0] vpid_e_i [N],
  input  logic [ROOT_W-1:0] root_e_i [N],
  input  logic [LPN_W-1:0]  page_e_i [N],
  input  logic [PFN_W-1:0]  frame_e_i [N],
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic [PFN_W-1:0]  frame_o
);
  import tlbi_pkg::*;

  logic [N-1:0]     match;
  logic             hit_d;
  logic [PFN_W-1:0] frame_d;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic v_eq, r_eq, ctx_ok;
    assign v_eq = (vpid_e_i[i] == vpid_i);
    assign r_eq = (root_e_i[i] == root_i);
    always_comb begin
      case (kind_i[i])
        KIND_VPID: ctx_ok = v_eq;
        KIND_ROOT: ctx_ok = r_eq;
        KIND_DUAL: ctx_ok = v_eq && r_eq;
        default:   ctx_ok = 1'b0;
      endcase
    end
    assign match[i] = valid_i[i] && ctx_ok && (page_e_i[i] == page_i);
  end

  // lowest slot wins
  always_comb begin
    hit_d   = 1'b0;
    frame_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_d   = 1'b1;
        frame_d = frame_e_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      frame_o      <= '0;
    end else begin
      resp_valid_o <= req_i;
      hit_o        <= req_i && hit_d;
      frame_o      <= (req_i && hit_d) ? frame_d : '0;
    end
  end

  AST_RESP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_i)); // R2
  AST_NO_STRAY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (!hit_o && frame_o == '0)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !hit_o) |-> frame_o == '0); // R2
endmodule

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl #(
  parameter int ENTRIES = 16,
  parameter int LANES = 4,
  parameter int VPID_W = 16,
  parameter int ROOT_W = 12,
  parameter int LPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPID_W-1:0] lk_vpid_i,
  input  logic [ROOT_W-1:0] lk_root_i,
  input  logic [LPN_W-1:0]  lk_page_i,
  output logic              lk_ready_o,
  output logic              lk_resp_valid_o,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_frame_o,
  input  logic              fill_valid_i,
  input  logic [1:0]        fill_kind_i,
  input  logic [VPID_W-1:0] fill_vpid_i,
  input  logic [ROOT_W-1:0] fill_root_i,
  input  logic [LPN_W-1:0]  fill_page_i,
  input  logic [PFN_W-1:0]  fill_frame_i,
  input  logic              fill_global_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [VPID_W-1:0] cmd_vpid_i,
  input  logic [ROOT_W-1:0] cmd_root_i,
  input  logic [LPN_W-1:0]  cmd_page_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int GROUPS = ENTRIES / LANES;
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic              busy, fill_en;
  logic [GRP_W-1:0]  sw_grp;
  logic [2:0]        sw_op;
  logic [VPID_W-1:0] sw_vpid;
  logic [ROOT_W-1:0] sw_root;
  logic [LPN_W-1:0]  sw_page;
  logic [IDX_W-1:0]  ptr_q;

  logic [ENTRIES-1:0] e_valid;
  logic [1:0]         e_kind  [ENTRIES];
  logic [VPID_W-1:0]  e_vpid  [ENTRIES];
  logic [ROOT_W-1:0]  e_root  [ENTRIES];
  logic [LPN_W-1:0]   e_page  [ENTRIES];
  logic [PFN_W-1:0]   e_frame [ENTRIES];

  assign lk_ready_o  = !busy;
  assign cmd_ready_o = !busy;
  assign fill_en     = fill_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  tlbi_sweeper #(
    .N(ENTRIES), .LANES(LANES), .VPID_W(VPID_W), .ROOT_W(ROOT_W), .LPN_W(LPN_W)
  ) u_sweep (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_op_i, .cmd_vpid_i, .cmd_root_i, .cmd_page_i,
    .busy_o(busy), .done_o, .err_o,
    .grp_o(sw_grp), .op_o(sw_op), .vpid_o(sw_vpid), .root_o(sw_root), .page_o(sw_page)
  );

  tlbi_entry_store #(
    .N(ENTRIES), .LANES(LANES), .VPID_W(VPID_W), .ROOT_W(ROOT_W),
    .LPN_W(LPN_W), .PFN_W(PFN_W)
  ) u_store (
    .clk_i, .rst_ni,
    .fill_en_i(fill_en), .fill_idx_i(ptr_q), .fill_kind_i, .fill_vpid_i,
    .fill_root_i, .fill_page_i, .fill_frame_i, .fill_glb_i(fill_global_i),
    .sw_act_i(busy), .sw_grp_i(sw_grp), .sw_op_i(sw_op), .sw_vpid_i(sw_vpid),
    .sw_root_i(sw_root), .sw_page_i(sw_page),
    .valid_o(e_valid), .kind_o(e_kind), .vpid_o(e_vpid), .root_o(e_root),
    .page_o(e_page), .frame_o(e_frame)
  );

  tlbi_lookup #(
    .N(ENTRIES), .VPID_W(VPID_W), .ROOT_W(ROOT_W), .LPN_W(LPN_W), .PFN_W(PFN_W)
  ) u_lookup (
    .clk_i, .rst_ni,
    .req_i(lk_valid_i && !busy), .vpid_i(lk_vpid_i), .root_i(lk_root_i), .page_i(lk_page_i),
    .valid_i(e_valid), .kind_i(e_kind), .vpid_e_i(e_vpid), .root_e_i(e_root),
    .page_e_i(e_page), .frame_e_i(e_frame),
    .resp_valid_o(lk_resp_valid_o), .hit_o(lk_hit_o), .frame_o(lk_frame_o)
  );

  AST_NO_LOOKUP_IN_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_resp_valid_o |-> $past(lk_ready_o)); // R12
  AST_RR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en |=> $stable(ptr_q)); // R3
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R11
endmodule

// File: tb/tb_tlb_inval_ctrl.sv
module tb_tlb_inval_ctrl;
  localparam int N = 16;
  localparam int GROUPS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0;
  logic [15:0] lk_vpid = 0;
  logic [11:0] lk_root = 0;
  logic [19:0] lk_page = 0;
  logic        lk_ready, lk_resp_valid, lk_hit;
  logic [19:0] lk_frame;
  logic        fill_valid = 0;
  logic [1:0]  fill_kind = 0;
  logic [15:0] fill_vpid = 0;
  logic [11:0] fill_root = 0;
  logic [19:0] fill_page = 0;
  logic [19:0] fill_frame = 0;
  logic        fill_global = 0;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_op = 0;
  logic [15:0] cmd_vpid = 0;
  logic [11:0] cmd_root = 0;
  logic [19:0] cmd_page = 0;
  logic        cmd_ready, done, err;

  int total = 0;
  int bad = 0;

  always #2ns clk = ~clk;

  tlb_inval_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vpid_i(lk_vpid), .lk_root_i(lk_root), .lk_page_i(lk_page),
    .lk_ready_o(lk_ready), .lk_resp_valid_o(lk_resp_valid), .lk_hit_o(lk_hit),
    .lk_frame_o(lk_frame),
    .fill_valid_i(fill_valid), .fill_kind_i(fill_kind), .fill_vpid_i(fill_vpid),
    .fill_root_i(fill_root), .fill_page_i(fill_page), .fill_frame_i(fill_frame),
    .fill_global_i(fill_global),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_vpid_i(cmd_vpid),
    .cmd_root_i(cmd_root), .cmd_page_i(cmd_page),
    .cmd_ready_o(cmd_ready), .done_o(done), .err_o(err)
  );

  // reference model
  bit          m_v [N];
  logic [1:0]  m_k [N];
  logic [15:0] m_vp [N];
  logic [11:0] m_rt [N];
  logic [19:0] m_pg [N];
  logic [19:0] m_fr [N];
  bit          m_g [N];
  int          m_ptr = 0;

  typedef struct { bit hit; logic [19:0] frame; string req; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void mlook(input logic [15:0] vp, input logic [11:0] rt,
                                input logic [19:0] pg, output bit h, output logic [19:0] f);
    h = 0; f = '0;
    for (int s = N - 1; s >= 0; s--) begin
      bit ok;
      case (m_k[s])
        2'd1: ok = (m_vp[s] == vp);
        2'd2: ok = (m_rt[s] == rt);
        2'd3: ok = (m_vp[s] == vp) && (m_rt[s] == rt);
        default: ok = 0;
      endcase
      if (m_v[s] && ok && m_pg[s] == pg) begin h = 1; f = m_fr[s]; end
    end
  endfunction

  function automatic void mclear(input int op, input logic [15:0] vp,
                                 input logic [11:0] rt, input logic [19:0] pg);
    for (int s = 0; s < N; s++) begin
      bit hv, hr, c;
      hv = m_k[s][0]; hr = m_k[s][1];
      case (op)
        0: c = hv && m_vp[s] == vp && m_pg[s] == pg;
        1: c = hv && m_vp[s] == vp;
        2: c = hv;
        3: c = hv && m_vp[s] == vp && !m_g[s];
        4: c = hr && m_rt[s] == rt;
        5: c = hv && m_vp[s] == 0;
        6: c = hv && hr && m_vp[s] == vp && m_rt[s] == rt && m_pg[s] == pg;
        default: c = 0;
      endcase
      if (c) m_v[s] = 0;
    end
  endfunction

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && lk_resp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected response", 32'(lk_hit), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(lk_hit == e.hit && lk_frame == (e.hit ? e.frame : 20'h0), e.req,
            {11'h0, lk_hit, lk_frame}, {11'h0, e.hit, (e.hit ? e.frame : 20'h0)});
      end
    end
  end

  task automatic lookup(input logic [15:0] vp, input logic [11:0] rt,
                        input logic [19:0] pg, input string req);
    exp_t e;
    @(negedge clk);
    mlook(vp, rt, pg, e.hit, e.frame);
    e.req = req;
    exp_q.push_back(e);
    lk_valid = 1; lk_vpid = vp; lk_root = rt; lk_page = pg;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic lookup_exp(input logic [15:0] vp, input logic [11:0] rt,
                            input logic [19:0] pg, input bit h, input string req);
    exp_t e;
    @(negedge clk);
    e.hit = h; e.frame = '0; e.req = req;
    if (h) begin bit hh; mlook(vp, rt, pg, hh, e.frame); end
    exp_q.push_back(e);
    lk_valid = 1; lk_vpid = vp; lk_root = rt; lk_page = pg;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < N; s++)
      if (m_k[s] != 0) lookup(m_vp[s], m_rt[s], m_pg[s], req);
  endtask

  task automatic fill(input logic [1:0] k, input logic [15:0] vp, input logic [11:0] rt,
                      input logic [19:0] pg, input logic [19:0] fr, input bit g);
    @(negedge clk);
    fill_valid = 1; fill_kind = k; fill_vpid = vp; fill_root = rt;
    fill_page = pg; fill_frame = fr; fill_global = g;
    m_v[m_ptr] = 1; m_k[m_ptr] = k; m_vp[m_ptr] = vp; m_rt[m_ptr] = rt;
    m_pg[m_ptr] = pg; m_fr[m_ptr] = fr; m_g[m_ptr] = g;
    m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(input int op, input logic [15:0] vp, input logic [11:0] rt,
                       input logic [19:0] pg, input string req, input bit probe);
    @(negedge clk);
    chk(cmd_ready == 1, "R12 ready before command", 32'(cmd_ready), 32'h1);
    cmd_valid = 1; cmd_op = 3'(op); cmd_vpid = vp; cmd_root = rt; cmd_page = pg;
    @(negedge clk);
    cmd_valid = 0;
    if (op == 7) begin
      chk(err == 1 && lk_ready == 1 && done == 0, "R11 err pulse, no sweep",
          {29'h0, err, lk_ready, done}, 32'h6);
      @(negedge clk);
      chk(err == 0 && done == 0, "R11 err one cycle", {30'h0, err, done}, 32'h0);
    end else begin
      mclear(op, vp, rt, pg);
      chk(lk_ready == 0 && done == 0, "R12 busy after accept", {30'h0, lk_ready, done}, 32'h0);
      if (probe) begin
        lk_valid = 1; lk_vpid = 16'h0077; lk_root = 12'h077; lk_page = 20'h7FF00;
        fill_valid = 1; fill_kind = 2'd1; fill_vpid = 16'h0077;
        fill_page = 20'h7FF00; fill_frame = 20'hDEAD0; fill_global = 0;
      end
      for (int c = 1; c < GROUPS; c++) begin
        @(negedge clk);
        chk(lk_ready == 0 && done == 0 && lk_resp_valid == 0, "R12 stall during sweep",
            {29'h0, lk_ready, done, lk_resp_valid}, 32'h0);
      end
      lk_valid = 0; fill_valid = 0;
      @(negedge clk);
      chk(done == 1 && lk_ready == 1, "R12 done after last group", {30'h0, done, lk_ready}, 32'h3);
      @(negedge clk);
      chk(done == 0, "R12 done single cycle", 32'(done), 32'h0);
    end
    check_all(req);
  endtask

  initial begin
    #800us;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      m_v[s] = 0; m_k[s] = 0; m_vp[s] = 0; m_rt[s] = 0; m_pg[s] = 0; m_fr[s] = 0; m_g[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk(lk_ready == 1 && done == 0 && err == 0 && lk_resp_valid == 0, "R1 reset outputs",
        {28'h0, lk_ready, done, err, lk_resp_valid}, 32'h8);
    rst_n = 1;
    lookup_exp(16'h5, 12'h3, 20'h00100, 0, "R1 miss after reset");

    fill(2'd1, 16'h5, 12'h0, 20'h00100, 20'hA0000, 0); // 0
    fill(2'd3, 16'h5, 12'h3, 20'h00101, 20'hA0001, 0); // 1
    fill(2'd3, 16'h5, 12'h4, 20'h00101, 20'hA0002, 0); // 2
    fill(2'd2, 16'h0, 12'h3, 20'h00200, 20'hA0003, 0); // 3
    fill(2'd1, 16'h5, 12'h0, 20'h00102, 20'hA0004, 1); // 4 global
    fill(2'd1, 16'h0, 12'h0, 20'h00300, 20'hA0005, 0); // 5
    fill(2'd3, 16'h0, 12'h7, 20'h00301, 20'hA0006, 0); // 6
    fill(2'd1, 16'h9, 12'h0, 20'h00100, 20'hA0007, 0); // 7
    fill(2'd2, 16'h0, 12'h4, 20'h00201, 20'hA0008, 0); // 8
    fill(2'd3, 16'h9, 12'h3, 20'h00400, 20'hA0009, 0); // 9
    fill(2'd1, 16'h9, 12'h0, 20'h00400, 20'hA000A, 0); // 10

    check_all("R2 hit per kind");
    lookup_exp(16'h5, 12'h9, 20'h00101, 0, "R2 dual root mismatch");
    lookup_exp(16'h6, 12'h0, 20'h00100, 0, "R2 vpid mismatch");
    lookup_exp(16'h1234, 12'h3, 20'h00200, 1, "R2 root kind ignores vpid");
    lookup_exp(16'h5, 12'h0, 20'h00102, 1, "R2 vpid kind ignores root");

    inval(0, 16'h5, 12'h0, 20'h00101, "R4 op0 vpid+addr all roots", 0);
    lookup_exp(16'h5, 12'h4, 20'h00101, 0, "R4 dual other root cleared");
    inval(6, 16'h9, 12'h3, 20'h00400, "R10 fault dual only", 0);
    lookup_exp(16'h9, 12'h0, 20'h00400, 1, "R10 vpid-tagged kept");
    inval(7, 16'h5, 12'h3, 20'h00100, "R11 undefined no change", 0);
    inval(3, 16'h5, 12'h0, 20'h0, "R7 op3 keeps global", 1);
    lookup_exp(16'h5, 12'h0, 20'h00102, 1, "R7 global survives");
    lookup_exp(16'h0077, 12'h077, 20'h7FF00, 0, "R3 fill during sweep ignored");
    inval(1, 16'h5, 12'h0, 20'h0, "R5 op1 clears vpid", 0);
    lookup_exp(16'h5, 12'h0, 20'h00102, 0, "R5 global cleared by op1");
    inval(4, 16'h0, 12'h3, 20'h0, "R8 op4 root", 0);
    lookup_exp(16'h0, 12'h4, 20'h00201, 1, "R8 other root kept");
    inval(5, 16'h0, 12'h0, 20'h0, "R9 op5 vpid zero", 0);
    lookup_exp(16'h0, 12'h7, 20'h00301, 0, "R9 dual vpid0 cleared");

    fill(2'd1, 16'h3, 12'h0, 20'h00500, 20'hB0000, 1); // 11
    fill(2'd3, 16'h4, 12'h2, 20'h00501, 20'hB0001, 0); // 12
    inval(2, 16'h0, 12'h0, 20'h0, "R6 op2 all vpid", 0);
    lookup_exp(16'h0, 12'h4, 20'h00201, 1, "R6 root kind kept");
    lookup_exp(16'h3, 12'h0, 20'h00500, 0, "R6 global vpid cleared");

    // wrap: slots 13..15 then 0 again
    fill(2'd1, 16'h2, 12'h0, 20'h00600, 20'hC0000, 0);
    fill(2'd1, 16'h2, 12'h0, 20'h00601, 20'hC0001, 0);
    fill(2'd1, 16'h2, 12'h0, 20'h00602, 20'hC0002, 0);
    fill(2'd2, 16'h0, 12'h5, 20'h00700, 20'hC0003, 0); // slot 0
    fill(2'd2, 16'h0, 12'h5, 20'h00701, 20'hC0004, 0); // slot 1
    check_all("R3 round robin wrap");
    lookup_exp(16'h0, 12'h5, 20'h00700, 1, "R3 wrapped fill in slot 0");
    fill(2'd2, 16'h0, 12'h6, 20'h00800, 20'hC0005, 0); // slot 2
    fill(2'd2, 16'h0, 12'h6, 20'h00801, 20'hC0006, 0); // slot 3
    fill(2'd2, 16'h0, 12'h6, 20'h00802, 20'hC0007, 0); // slot 4
    fill(2'd2, 16'h0, 12'h6, 20'h00803, 20'hC0008, 0); // slot 5
    fill(2'd2, 16'h0, 12'h6, 20'h00804, 20'hC0009, 0); // slot 6
    fill(2'd2, 16'h0, 12'h6, 20'h00805, 20'hC000A, 0); // slot 7
    fill(2'd2, 16'h0, 12'h6, 20'h00806, 20'hC000B, 0); // slot 8 replaces root4 entry
    lookup_exp(16'h0, 12'h4, 20'h00201, 0, "R3 oldest replaced");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule